// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block drives the programmable feedback counter of a fractional-N synthesizer. It runs on the feedback-rate clock and counts down from a divide value. At each terminal count it emits one pulse and reloads with a fresh value. The values it picks wander around a whole number, and over time their mean settles on INT + FRAC/MOD. MOD is any modulus from 2 to 4095 and need not be a power of two.

The fraction is shaped by a cascade of three first-order accumulators. Each accumulator wraps modulo MOD, and their carries are combined into a correction from -3 to +4. The cascade steps once per terminal count.

Settings come in through a one-cycle load strobe. Each set is checked against its legal ranges and then held in a shadow stage. It goes live on a later terminal count, and at that moment the accumulators are cleared. An out-of-range set is dropped and raises an error flag. An integer-mode input stops the fraction so that every count equals INT. The settings pins are plain control inputs with no valid/ready handshake: the block never pushes back, and a load strobe is always taken in the cycle it is high.

Top module: `fracn_seq`

## Requirements
- R1: During reset and in the first cycle after release, `div_pulse` is 1, `ratio` reads 1 and `set_err` is 0. The next count uses the reset settings (INT 100, FRAC 0, MOD 2, `set_pre8` 0), so it lasts exactly 100 cycles.
- R2: Each count lasts exactly as many clock cycles as the value on `ratio` during that count. `div_pulse` is high only in the last cycle of each count, so there is one pulse per count.
- R3: A load is legal only if all of these hold: 23 <= INT <= 32767 when `set_pre8` = 0 (4/5 prescaler); 75 <= INT <= 65535 when `set_pre8` = 1 (8/9 prescaler); 2 <= MOD <= 4095; and FRAC < MOD. On an illegal load, `set_err` reads 1 from the next cycle on and the divide sequence carries on unchanged. A later legal load clears `set_err`. `set_err` changes only on cycles with a load.
- R4: A legal set captured on a clock edge goes live at the first terminal count after that edge. The count that ends at that terminal count still uses the old settings. The accumulators start from zero, so the first new count equals INT exactly.
- R5: While fractional operation is running, every count lies between INT-3 and INT+4.
- R6: Starting from the first count after new settings go live, take the sum of MOD*k consecutive counts. It equals MOD*k*INT + k*FRAC + e, where the end term e is in -1..+2.
- R7: While `int_mode` is 1 at a terminal count, the next count equals INT whatever FRAC is, and the accumulators are held at zero. After `int_mode` returns to 0, the sequence restarts from zero state. With FRAC = 0 every count equals INT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Feedback-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_int | input | 16 | Integer part of the divide value |
| set_frac | input | 12 | Fraction numerator |
| set_mod | input | 12 | Fraction modulus |
| set_pre8 | input | 1 | Prescaler mode: 0 selects 4/5, 1 selects 8/9 |
| set_load | input | 1 | One-cycle strobe that captures the settings |
| int_mode | input | 1 | Forces pure integer division |
| div_pulse | output | 1 | One pulse per completed count |
| ratio | output | 17 | Length of the count in progress |
| set_err | output | 1 | Last load was out of range |

## Verification
The assertions rely on the legal ranges keeping every divide value at 20 or more, so a pulse is never followed by another pulse in the next cycle. They also expect settings to be sampled only on `set_load` cycles, while `int_mode` may change at any time. The stimulus raises `set_load` and changes `int_mode` only in the last cycle of a count. That cycle both tests the case where a load coincides with a terminal count and keeps every measured window aligned to count boundaries. The illegal loads reach each range edge (INT 22, 32768 and 74, MOD 1, FRAC equal to MOD), and the legal boundary INT 75 is loaded in 8/9 mode with MOD 4095.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int INT_W   = 16;
  localparam int MOD_W   = 12;
  localparam int RATIO_W = INT_W + 1;
  localparam int CORR_W  = 4;
  localparam int STAGES  = 3;

  typedef struct packed {
    logic             pre8;
    logic [INT_W-1:0] ival;
    logic [MOD_W-1:0] frac;
    logic [MOD_W-1:0] modv;
  } fn_set_t;
endpackage

// File: rtl/fracn_cfg.sv
module fracn_cfg
  import fracn_pkg::*;
#(
  parameter int LO4     = 23,
  parameter int HI4     = 32767,
  parameter int LO8     = 75,
  parameter int HI8     = 65535,
  parameter int MODLO   = 2,
  parameter int MODHI   = 4095,
  parameter int RST_INT = 100,
  parameter int RST_MOD = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ld,
  input  fn_set_t ld_set,
  input  logic    tc,
  output fn_set_t eff,
  output logic    apply,
  output logic    err,
  output logic [INT_W-1:0] act_ival
);
  localparam logic [INT_W-1:0] L4 = INT_W'(LO4);
  localparam logic [INT_W-1:0] H4 = INT_W'(HI4);
  localparam logic [INT_W-1:0] L8 = INT_W'(LO8);
  localparam logic [INT_W-1:0] H8 = INT_W'(HI8);
  localparam logic [MOD_W-1:0] ML = MOD_W'(MODLO);
  localparam logic [MOD_W-1:0] MH = MOD_W'(MODHI);

  fn_set_t act_q, pend_q;
  logic    pend_v;
  logic    int_ok, mod_ok, frac_ok, legal, take;

  always_comb begin
    int_ok  = ld_set.pre8 ? (ld_set.ival >= L8 && ld_set.ival <= H8)
                          : (ld_set.ival >= L4 && ld_set.ival <= H4);
    mod_ok  = (ld_set.modv >= ML) && (ld_set.modv <= MH);
    frac_ok = ld_set.frac < ld_set.modv;
    legal   = int_ok && mod_ok && frac_ok;
    take    = ld && legal;
  end

  // Shadow set goes live on the terminal count that follows its capture.
  assign apply    = tc && pend_v;
  assign eff      = apply ? pend_q : act_q;
  assign act_ival = act_q.ival;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q      <= '0;
      act_q.ival <= INT_W'(RST_INT);
      act_q.modv <= MOD_W'(RST_MOD);
      pend_q     <= '0;
      pend_v     <= 1'b0;
      err        <= 1'b0;
    end else begin
      if (apply) act_q <= pend_q;
      if (take)  pend_q <= ld_set;
      pend_v <= take ? 1'b1 : (apply ? 1'b0 : pend_v);
      if (ld)    err <= !legal;
    end
  end
endmodule

// File: rtl/fracn_mash.sv
module fracn_mash
  import fracn_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step,
  input  logic                     clr,
  input  logic                     hold,
  input  logic [MOD_W-1:0]         frac,
  input  logic [MOD_W-1:0]         modv,
  output logic signed [CORR_W-1:0] corr
);
  logic [MOD_W-1:0] acc_q  [STAGES];
  logic [MOD_W-1:0] base   [STAGES];
  logic [MOD_W-1:0] addend [STAGES];
  logic [MOD_W-1:0] acc_nx [STAGES];
  logic [MOD_W:0]   sum    [STAGES];
  logic [STAGES-1:0] cy;
  logic c2_d, c3_d, c3_dd;
  logic c2d_b, c3d_b, c3dd_b;
  logic [CORR_W-1:0] corr_raw;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    assign base[g] = clr ? '0 : acc_q[g];
    if (g == 0) begin : g_first
      assign addend[g] = frac;
    end else begin : g_next
      assign addend[g] = acc_nx[g-1];
    end
    assign sum[g]    = {1'b0, base[g]} + {1'b0, addend[g]};
    assign cy[g]     = sum[g] >= {1'b0, modv};
    assign acc_nx[g] = cy[g] ? MOD_W'(sum[g] - {1'b0, modv}) : sum[g][MOD_W-1:0];
  end

  assign c2d_b  = clr ? 1'b0 : c2_d;
  assign c3d_b  = clr ? 1'b0 : c3_d;
  assign c3dd_b = clr ? 1'b0 : c3_dd;

  // c1 + (1-z)c2 + (1-z)^2 c3, modular in CORR_W bits
  assign corr_raw = CORR_W'(cy[0]) + CORR_W'(cy[1]) - CORR_W'(c2d_b)
                  + CORR_W'(cy[2]) - CORR_W'({c3d_b, 1'b0}) + CORR_W'(c3dd_b);
  assign corr = hold ? '0 : $signed(corr_raw);

  always_ff @(posedge clk) begin
    if (!rst_n || (step && hold)) begin
      for (int i = 0; i < STAGES; i++) acc_q[i] <= '0;
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else if (step) begin
      for (int i = 0; i < STAGES; i++) acc_q[i] <= acc_nx[i];
      c2_d  <= cy[1];
      c3_d  <= cy[2];
      c3_dd <= c3d_b;
    end
  end
endmodule

// File: rtl/fracn_cnt.sv
module fracn_cnt
  import fracn_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] nxt,
  output logic               tc,
  output logic [RATIO_W-1:0] cur
);
  logic [RATIO_W-1:0] cnt_q;

  assign tc = cnt_q == RATIO_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= RATIO_W'(1);
      cur   <= RATIO_W'(1);
    end else if (tc) begin
      cnt_q <= nxt;
      cur   <= nxt;
    end else begin
      cnt_q <= cnt_q - RATIO_W'(1);
    end
  end
endmodule

// File: rtl/fracn_seq.sv
module fracn_seq
  import fracn_pkg::*;
#(
  parameter int LO4     = 23,
  parameter int HI4     = 32767,
  parameter int LO8     = 75,
  parameter int HI8     = 65535,
  parameter int MODLO   = 2,
  parameter int MODHI   = 4095,
  parameter int RST_INT = 100,
  parameter int RST_MOD = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INT_W-1:0]   set_int,
  input  logic [MOD_W-1:0]   set_frac,
  input  logic [MOD_W-1:0]   set_mod,
  input  logic               set_pre8,
  input  logic               set_load,
  input  logic               int_mode,
  output logic               div_pulse,
  output logic [RATIO_W-1:0] ratio,
  output logic               set_err
);
  fn_set_t ld_set, eff;
  logic    tc, apply;
  logic [INT_W-1:0] act_int;
  logic signed [CORR_W-1:0]  corr;
  logic signed [RATIO_W:0]   ratio_s;
  logic [RATIO_W-1:0]        ratio_nxt;

  assign ld_set = '{pre8: set_pre8, ival: set_int, frac: set_frac, modv: set_mod};

  fracn_cfg #(
    .LO4(LO4), .HI4(HI4), .LO8(LO8), .HI8(HI8),
    .MODLO(MODLO), .MODHI(MODHI), .RST_INT(RST_INT), .RST_MOD(RST_MOD)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .ld(set_load), .ld_set(ld_set), .tc(tc),
    .eff(eff), .apply(apply), .err(set_err), .act_ival(act_int)
  );

  fracn_mash u_mash (
    .clk(clk), .rst_n(rst_n), .step(tc), .clr(apply), .hold(int_mode),
    .frac(eff.frac), .modv(eff.modv), .corr(corr)
  );

  assign ratio_s   = $signed({2'b00, eff.ival})
                   + $signed({{(RATIO_W + 1 - CORR_W){corr[CORR_W-1]}}, corr});
  assign ratio_nxt = ratio_s[RATIO_W-1:0];

  fracn_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .nxt(ratio_nxt), .tc(tc), .cur(ratio)
  );

  assign div_pulse = tc;
endmodule

// File: rtl/fracn_seq_chk.sv
module fracn_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        div_pulse,
  input logic [16:0] ratio,
  input logic        set_load,
  input logic [11:0] set_frac,
  input logic [11:0] set_mod,
  input logic        set_err,
  input logic        int_mode,
  input logic [15:0] act_int
);
  p_one_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  p_ratio_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !div_pulse |=> $stable(ratio));

  p_err_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !set_load |=> $stable(set_err));

  p_err_frac_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_load && (set_frac >= set_mod)) |=> set_err);

  p_ratio_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> ((18'(ratio) + 18'd3 >= 18'(act_int)) && (18'(ratio) <= 18'(act_int) + 18'd4)));

  p_intmode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pulse && int_mode) |=> (ratio == {1'b0, act_int}));
endmodule

bind fracn_seq fracn_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .div_pulse(div_pulse), .ratio(ratio),
  .set_load(set_load), .set_frac(set_frac), .set_mod(set_mod),
  .set_err(set_err), .int_mode(int_mode), .act_int(act_int)
);

// File: tb/fracn_seq_tb_top.sv
module fracn_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] set_int = 16'd0;
  logic [11:0] set_frac = 12'd0;
  logic [11:0] set_mod = 12'd2;
  logic        set_pre8 = 1'b0;
  logic        set_load = 1'b0;
  logic        int_mode = 1'b0;
  logic        div_pulse;
  logic [16:0] ratio;
  logic        set_err;

  int n_chk = 0;
  int n_fail = 0;
  int lag = 0;

  always #2 clk = ~clk;

  fracn_seq dut_i (
    .clk(clk), .rst_n(rst_n), .set_int(set_int), .set_frac(set_frac),
    .set_mod(set_mod), .set_pre8(set_pre8), .set_load(set_load),
    .int_mode(int_mode), .div_pulse(div_pulse), .ratio(ratio), .set_err(set_err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a pulse cycle (negedge); returns length and reported ratio of the next count.
  task automatic get_count(output int len, output int r);
    len = lag;
    lag = 0;
    do begin
      @(negedge clk);
      len++;
    end while (div_pulse !== 1'b1);
    r = int'(ratio);
    check(len == r, "R2 count length vs ratio", len, r);
  endtask

  // Drives a one-cycle load starting at a pulse cycle; returns the error flag after it.
  task automatic do_load(input int iv, input int fv, input int mv, input bit p8, output bit e);
    set_int = 16'(iv); set_frac = 12'(fv); set_mod = 12'(mv); set_pre8 = p8;
    set_load = 1'b1;
    @(negedge clk);
    set_load = 1'b0;
    lag = 1;
    e = set_err;
  endtask

  task automatic t_reset();
    int len, r;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(div_pulse === 1'b1, "R1 pulse after reset", div_pulse, 1);
    check(ratio == 17'd1, "R1 ratio after reset", ratio, 1);
    check(set_err === 1'b0, "R1 err after reset", set_err, 0);
    get_count(len, r);
    check(r == 100, "R1 first count uses reset INT", r, 100);
  endtask

  task automatic t_apply();
    int len, r;
    bit e;
    do_load(250, 0, 2, 1'b0, e);
    check(e == 1'b0, "R3 legal load err", e, 0);
    get_count(len, r);
    check(r == 100, "R4 count in flight keeps old INT", r, 100);
    get_count(len, r);
    check(r == 250, "R4 new INT after terminal count", r, 250);
  endtask

  task automatic t_frac(input int iv, input int fv, input int mv, input bit p8, input int k);
    int len, r;
    bit e;
    longint s = 0;
    longint base;
    do_load(iv, fv, mv, p8, e);
    check(e == 1'b0, "R3 legal fractional load", e, 0);
    get_count(len, r);
    for (int i = 0; i < mv * k; i++) begin
      get_count(len, r);
      if (i == 0) check(r == iv, "R4 first count equals INT", r, iv);
      check(r >= iv - 3 && r <= iv + 4, "R5 count within INT-3..INT+4", r, iv);
      s += r;
    end
    base = longint'(iv) * mv * k + longint'(fv) * k;
    check(s >= base - 1 && s <= base + 2, "R6 window sum", s, base);
  endtask

  task automatic t_illegal();
    int len, r;
    bit e;
    int bad_i[5] = '{74, 32768, 22, 100, 100};
    int bad_f[5] = '{0, 0, 0, 0, 7};
    int bad_m[5] = '{2, 2, 2, 1, 7};
    bit bad_p[5] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    do_load(200, 0, 2, 1'b0, e);
    get_count(len, r);
    get_count(len, r);
    check(r == 200, "R7 FRAC zero gives INT", r, 200);
    for (int j = 0; j < 5; j++) begin
      do_load(bad_i[j], bad_f[j], bad_m[j], bad_p[j], e);
      check(e == 1'b1, "R3 illegal load raises err", e, 1);
      for (int c = 0; c < 2; c++) begin
        get_count(len, r);
        check(r == 200, "R3 illegal load leaves sequence", r, 200);
      end
    end
    do_load(75, 0, 4095, 1'b1, e);
    check(e == 1'b0, "R3 boundary INT 75 in 8/9 mode clears err", e, 0);
    get_count(len, r);
    check(r == 200, "R4 old INT until terminal count", r, 200);
    get_count(len, r);
    check(r == 75, "R3 boundary INT applied", r, 75);
  endtask

  task automatic t_intmode();
    int len, r;
    bit e;
    longint s = 0;
    do_load(100, 3, 7, 1'b0, e);
    get_count(len, r);
    int_mode = 1'b1;
    for (int i = 0; i < 10; i++) begin
      get_count(len, r);
      check(r == 100, "R7 integer mode holds INT", r, 100);
    end
    int_mode = 1'b0;
    for (int i = 0; i < 7; i++) begin
      get_count(len, r);
      s += r;
    end
    check(s >= 702 && s <= 705, "R7 restart after integer mode", s, 703);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_apply();
    t_frac(100, 3, 7, 1'b0, 3);
    t_frac(23, 1, 2, 1'b0, 20);
    t_frac(40, 5, 13, 1'b0, 13);
    t_frac(75, 999, 1000, 1'b1, 1);
    t_illegal();
    t_intmode();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule